// File: doc/BRIEF.md
# Broadcast Sound Source and Mute Controller

This block is the control logic that decides which audio source feeds a television's audio outputs and when the digital-to-analog converters are silenced. It watches per-frame status from a digital stereo sound decoder (frame alignment lost, error rate above limit, programme type) and a small register bank written over a simple address/data bus. From these it drives the select lines of the reserve-sound switch (decoder DACs, analog mono input or analog stereo input), the output matrix, per-channel DAC mutes, an auxiliary mute, a +6 dB gain enable and a status word for front-panel indicators.

A failing digital signal is debounced. It must be seen bad on several consecutive frame strobes before the controller reacts, and good on several more before it returns, so the audio does not chatter between sources. On failure the controller either falls back to the analog mono input or holds its current selection and mutes the DACs, depending on a reserve-sound enable bit. All state changes, register writes included, take effect at a frame-status strobe.

Top module: `snd_src_mute_ctl`

## Requirements
- R1: After reset the source select is 1 (analog mono), both DAC mutes and the auxiliary mute are 1, both matrix selects and the gain enable are 0, and the status source field reads 3.
- R2: A register write changes no output until the next cycle in which `frm_stb` is high; all outputs are registered and change only on the clock edge where `frm_stb` is 1.
- R3: The failure condition asserts on the BAD_N-th (default 4) consecutive strobe with `frm_lost` or `ber_high` set; any good strobe restarts the count.
- R4: The failure condition clears on the GOOD_N-th (default 8) consecutive good strobe; any bad strobe restarts the count.
- R5: In automatic mode (control bits 1 and 2 equal), if the failure condition holds and the reserve enable (control bit 0) is 1, the source select becomes 1 (analog mono).
- R6: In automatic mode, if the failure condition holds and the reserve enable is 0, the source select keeps its previous value and both DACs are muted.
- R7: In automatic mode, programme type 3 (data only) selects source 1 and mutes both DACs.
- R8: Control bit 1 set with bit 2 clear forces source 1; bit 2 set with bit 1 clear forces source 2 (analog stereo); with the failure condition clear and a sound programme in automatic mode the source is 0 (decoder DACs).
- R9: Both DACs are muted on any strobe that reports `frm_lost` or `ber_high`, and while the failure condition holds.
- R10: Programme type 2 (single mono channel) mutes the right DAC unless control bit 3 (mono on both DACs) is set.
- R11: `unmute_pin` sampled high at a strobe, or control bit 4, clears both DAC mutes regardless of every automatic rule.
- R12: Register 1 drives the outputs: bit 0 left matrix select, bit 1 right matrix select (1 = external input), bit 2 gain enable, bit 3 auxiliary mute.
- R13: The status word holds {right mute, left mute, source}, source 0/1/2 = decoder stereo/dual mono/single mono when the DACs are selected, and 3 when an analog input is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_stb | input | 1 | Frame-status strobe, one cycle per frame |
| frm_lost | input | 1 | Frame alignment lost, valid with strobe |
| ber_high | input | 1 | Error rate above limit, valid with strobe |
| app_type | input | 2 | Programme type: 0 stereo, 1 dual mono, 2 single mono, 3 data |
| unmute_pin | input | 1 | Hardware force-unmute, sampled at strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW | Register address: 0 control, 1 routing |
| wr_data | input | DW | Register write data |
| rsw_sel | output | 2 | Reserve switch: 0 DACs, 1 analog mono, 2 analog stereo |
| mtx_sel_l | output | 1 | Left output matrix select |
| mtx_sel_r | output | 1 | Right output matrix select |
| gain6_en | output | 1 | +6 dB output gain enable |
| aux_mute | output | 1 | Auxiliary output mute |
| dac_mute_l | output | 1 | Left DAC mute |
| dac_mute_r | output | 1 | Right DAC mute |
| status | output | 4 | {mute R, mute L, source[1:0]} |

## Verification
A miscounted debounce counter shows as a source or mute change one or more strobes early or late, so each consecutive bad or good run is checked strobe by strobe at the boundary. A wrong held selection only becomes visible at the first strobe after a failure with the reserve enable clear, so those sequences are driven from each possible prior source. A register applied too early shows at the ports in the cycle after the write, before any strobe, and is checked there.

// File: rtl/snd_pkg.sv
package snd_pkg;
   typedef enum logic [1:0] {
      APP_STEREO = 2'd0,
      APP_DUAL   = 2'd1,
      APP_M1     = 2'd2,
      APP_DATA   = 2'd3
   } app_e;

   typedef enum logic [1:0] {
      RSW_DAC    = 2'd0,
      RSW_MONO   = 2'd1,
      RSW_STEREO = 2'd2
   } rsw_e;

   typedef struct packed {
      logic unmute;
      logic m1_both;
      logic fs1;
      logic fs0;
      logic rs_en;
   } ctrl_t;

   typedef struct packed {
      logic aux_mute;
      logic gain6;
      logic mtx_r;
      logic mtx_l;
   } route_t;

   localparam int CTRL_W  = $bits(ctrl_t);
   localparam int ROUTE_W = $bits(route_t);
   localparam route_t ROUTE_RST = '{aux_mute: 1'b1, gain6: 1'b0, mtx_r: 1'b0, mtx_l: 1'b0};
   localparam logic [1:0] SRC_ANALOG = 2'd3;
endpackage

// File: rtl/snd_regbank.sv
module snd_regbank
   import snd_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 1,
   parameter bit SYNC_UPDATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          upd,
   output ctrl_t         pend_ctrl,
   output ctrl_t         act_ctrl,
   output route_t        act_route
);
   localparam logic [AW-1:0] A_CTRL  = AW'(0);
   localparam logic [AW-1:0] A_ROUTE = AW'(1);

   ctrl_t  sh_ctrl;
   route_t sh_route;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ctrl  <= '0;
         sh_route <= ROUTE_RST;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL)  sh_ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == A_ROUTE) sh_route <= route_t'(wr_data[ROUTE_W-1:0]);
      end
   end

   assign pend_ctrl = sh_ctrl;

   generate
      if (SYNC_UPDATE) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_ctrl  <= '0;
               act_route <= ROUTE_RST;
            end else if (upd) begin
               act_ctrl  <= sh_ctrl;
               act_route <= sh_route;
            end
         end
      end else begin : g_imm
         logic unused_upd;
         assign unused_upd = upd;
         assign act_ctrl   = sh_ctrl;
         assign act_route  = sh_route;
      end

      if (DW > CTRL_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^wr_data[DW-1:CTRL_W];
      end
   endgenerate
endmodule

// File: rtl/snd_fail_deb.sv
module snd_fail_deb #(
   parameter int BAD_N  = 4,
   parameter int GOOD_N = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic bad,
   output logic failed_q,
   output logic failed_nxt
);
   localparam int BW = $clog2(BAD_N + 1);
   localparam int GW = $clog2(GOOD_N + 1);
   localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_N - 1);
   localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_N - 1);

   logic [BW-1:0] bad_cnt, bad_d;
   logic [GW-1:0] good_cnt, good_d;

   always_comb begin
      bad_d      = bad_cnt;
      good_d     = good_cnt;
      failed_nxt = failed_q;
      if (smp) begin
         if (bad) begin
            good_d = '0;
            if (!failed_q) begin
               if (bad_cnt == BAD_LAST) begin
                  failed_nxt = 1'b1;
                  bad_d      = '0;
               end else begin
                  bad_d = bad_cnt + 1'b1;
               end
            end
         end else begin
            bad_d = '0;
            if (failed_q) begin
               if (good_cnt == GOOD_LAST) begin
                  failed_nxt = 1'b0;
                  good_d     = '0;
               end else begin
                  good_d = good_cnt + 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_cnt  <= '0;
         good_cnt <= '0;
         failed_q <= 1'b1;
      end else begin
         bad_cnt  <= bad_d;
         good_cnt <= good_d;
         failed_q <= failed_nxt;
      end
   end
endmodule

// File: rtl/snd_route.sv
module snd_route
   import snd_pkg::*;
(
   input  ctrl_t      ctrl,
   input  app_e       app,
   input  logic       bad_now,
   input  logic       failed,
   input  logic       unmute_pin,
   input  rsw_e       rsw_cur,
   output rsw_e       rsw_d,
   output logic       mute_l_d,
   output logic       mute_r_d,
   output logic [1:0] src_d
);
   logic auto_l, auto_r, force_un;

   always_comb begin
      if (ctrl.fs0 && !ctrl.fs1)      rsw_d = RSW_MONO;
      else if (ctrl.fs1 && !ctrl.fs0) rsw_d = RSW_STEREO;
      else if (app == APP_DATA)       rsw_d = RSW_MONO;
      else if (failed)                rsw_d = ctrl.rs_en ? RSW_MONO : rsw_cur;
      else                            rsw_d = RSW_DAC;
   end

   assign auto_l   = bad_now || failed || (app == APP_DATA);
   assign auto_r   = auto_l || ((app == APP_M1) && !ctrl.m1_both);
   assign force_un = ctrl.unmute || unmute_pin;
   assign mute_l_d = auto_l && !force_un;
   assign mute_r_d = auto_r && !force_un;

   always_comb begin
      if (rsw_d != RSW_DAC) src_d = SRC_ANALOG;
      else begin
         case (app)
            APP_STEREO: src_d = 2'd0;
            APP_DUAL:   src_d = 2'd1;
            APP_M1:     src_d = 2'd2;
            default:    src_d = SRC_ANALOG;
         endcase
      end
   end
endmodule

// File: rtl/snd_src_mute_ctl.sv
module snd_src_mute_ctl
   import snd_pkg::*;
#(
   parameter int BAD_N       = 4,
   parameter int GOOD_N      = 8,
   parameter int DW          = 8,
   parameter int AW          = 1,
   parameter bit SYNC_UPDATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_stb,
   input  logic          frm_lost,
   input  logic          ber_high,
   input  logic [1:0]    app_type,
   input  logic          unmute_pin,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [1:0]    rsw_sel,
   output logic          mtx_sel_l,
   output logic          mtx_sel_r,
   output logic          gain6_en,
   output logic          aux_mute,
   output logic          dac_mute_l,
   output logic          dac_mute_r,
   output logic [3:0]    status
);
   initial begin
      if (BAD_N < 1 || GOOD_N < 1) $error("debounce lengths must be at least 1");
      if (DW < CTRL_W)             $error("data width too small for control register");
      if (AW < 1)                  $error("address width must be at least 1");
   end

   ctrl_t  pend_ctrl, act_ctrl;
   route_t act_route;
   logic   failed_q, failed_nxt;
   rsw_e   rsw_q, rsw_d;
   logic   mute_l_q, mute_r_q, mute_l_d, mute_r_d;
   logic [1:0] src_q, src_d;
   logic   bad_now;

   assign bad_now = frm_lost || ber_high;

   snd_regbank #(.DW(DW), .AW(AW), .SYNC_UPDATE(SYNC_UPDATE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .upd(frm_stb), .pend_ctrl(pend_ctrl), .act_ctrl(act_ctrl), .act_route(act_route)
   );

   snd_fail_deb #(.BAD_N(BAD_N), .GOOD_N(GOOD_N)) u_deb (
      .clk(clk), .rst_n(rst_n), .smp(frm_stb), .bad(bad_now),
      .failed_q(failed_q), .failed_nxt(failed_nxt)
   );

   snd_route u_route (
      .ctrl(pend_ctrl), .app(app_e'(app_type)), .bad_now(bad_now), .failed(failed_nxt),
      .unmute_pin(unmute_pin), .rsw_cur(rsw_q), .rsw_d(rsw_d),
      .mute_l_d(mute_l_d), .mute_r_d(mute_r_d), .src_d(src_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsw_q    <= RSW_MONO;
         mute_l_q <= 1'b1;
         mute_r_q <= 1'b1;
         src_q    <= SRC_ANALOG;
      end else if (frm_stb) begin
         rsw_q    <= rsw_d;
         mute_l_q <= mute_l_d;
         mute_r_q <= mute_r_d;
         src_q    <= src_d;
      end
   end

   assign rsw_sel    = rsw_q;
   assign dac_mute_l = mute_l_q;
   assign dac_mute_r = mute_r_q;
   assign status     = {mute_r_q, mute_l_q, src_q};
   assign mtx_sel_l  = act_route.mtx_l;
   assign mtx_sel_r  = act_route.mtx_r;
   assign gain6_en   = act_route.gain6;
   assign aux_mute   = act_route.aux_mute;
endmodule

// File: rtl/snd_src_mute_chk.sv
module snd_src_mute_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_stb,
   input logic       frm_lost,
   input logic       ber_high,
   input logic [1:0] app_type,
   input logic       unmute_pin,
   input logic [1:0] rsw_sel,
   input logic       dac_mute_l,
   input logic       dac_mute_r,
   input logic [3:0] status,
   input logic       act_fs0,
   input logic       act_fs1,
   input logic       act_unmute,
   input logic       act_m1both,
   input logic       failed_q
);
   // R2
   hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_stb |=> $stable(rsw_sel) && $stable(dac_mute_l) && $stable(dac_mute_r) && $stable(status));

   // R3
   fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(failed_q) |-> $past(frm_stb) && $past(frm_lost || ber_high));

   // R4
   fail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(failed_q) |-> $past(frm_stb) && !$past(frm_lost || ber_high));

   // R8
   forced_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb |=> (!(act_fs0 && !act_fs1) || rsw_sel == 2'd1) && (!(act_fs1 && !act_fs0) || rsw_sel == 2'd2));

   // R9
   bad_frame_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && (frm_lost || ber_high) && !unmute_pin |=> act_unmute || (dac_mute_l && dac_mute_r));

   // R10
   m1_right_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && app_type == 2'd2 && !unmute_pin |=> act_unmute || act_m1both || dac_mute_r);

   // R11
   pin_unmute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_stb && unmute_pin |=> !dac_mute_l && !dac_mute_r);

   // R13
   status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsw_sel != 2'd0) |-> status[1:0] == 2'd3);
endmodule

bind snd_src_mute_ctl snd_src_mute_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_lost(frm_lost), .ber_high(ber_high),
   .app_type(app_type), .unmute_pin(unmute_pin), .rsw_sel(rsw_sel),
   .dac_mute_l(dac_mute_l), .dac_mute_r(dac_mute_r), .status(status),
   .act_fs0(act_ctrl.fs0), .act_fs1(act_ctrl.fs1), .act_unmute(act_ctrl.unmute),
   .act_m1both(act_ctrl.m1_both), .failed_q(failed_q)
);

// File: tb/snd_src_mute_ctl_tb.sv
module snd_src_mute_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_stb = 0, frm_lost = 0, ber_high = 0, unmute_pin = 0, wr_en = 0;
   logic [1:0] app_type = 0;
   logic [0:0] wr_addr = 0;
   logic [7:0] wr_data = 0;
   logic [1:0] rsw_sel;
   logic       mtx_sel_l, mtx_sel_r, gain6_en, aux_mute, dac_mute_l, dac_mute_r;
   logic [3:0] status;

   int n_run = 0, n_fail = 0;

   // bench model state
   logic [4:0] p_ctrl = 0, a_ctrl = 0;
   logic [3:0] p_rt = 4'b1000, a_rt = 4'b1000;
   bit  m_fail = 1;
   int  m_bcnt = 0, m_gcnt = 0;
   logic [1:0] m_rsw = 1;
   bit  m_ml = 1, m_mr = 1;
   logic [1:0] m_src = 3;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   snd_src_mute_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_lost(frm_lost), .ber_high(ber_high),
      .app_type(app_type), .unmute_pin(unmute_pin), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rsw_sel(rsw_sel), .mtx_sel_l(mtx_sel_l), .mtx_sel_r(mtx_sel_r),
      .gain6_en(gain6_en), .aux_mute(aux_mute), .dac_mute_l(dac_mute_l),
      .dac_mute_r(dac_mute_r), .status(status)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_all();
      chk(rsw_sel == m_rsw, "R8 source select", rsw_sel, m_rsw);
      chk(dac_mute_l == m_ml, "R9 left DAC mute", dac_mute_l, m_ml);
      chk(dac_mute_r == m_mr, "R10 right DAC mute", dac_mute_r, m_mr);
      chk({aux_mute, gain6_en, mtx_sel_r, mtx_sel_l} == a_rt, "R12 routing outputs",
          {aux_mute, gain6_en, mtx_sel_r, mtx_sel_l}, a_rt);
      chk(status == {m_mr, m_ml, m_src}, "R13 status word", status, {m_mr, m_ml, m_src});
   endtask

   task automatic wr(input bit addr, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      if (addr) p_rt = d[3:0]; else p_ctrl = d[4:0];
   endtask

   // model derived from the requirements: ctrl bit0 rs_en, 1 fs0, 2 fs1, 3 m1_both, 4 unmute
   task automatic model(input bit lost, input bit ber, input logic [1:0] app, input bit pin);
      bit bad, al, ar, fu;
      a_ctrl = p_ctrl; a_rt = p_rt;
      bad = lost | ber;
      if (bad) begin
         m_gcnt = 0;
         if (!m_fail) begin m_bcnt++; if (m_bcnt == 4) begin m_fail = 1; m_bcnt = 0; end end
      end else begin
         m_bcnt = 0;
         if (m_fail) begin m_gcnt++; if (m_gcnt == 8) begin m_fail = 0; m_gcnt = 0; end end
      end
      if (a_ctrl[1] && !a_ctrl[2])      m_rsw = 1;
      else if (a_ctrl[2] && !a_ctrl[1]) m_rsw = 2;
      else if (app == 3)                m_rsw = 1;
      else if (m_fail)                  m_rsw = a_ctrl[0] ? 2'd1 : m_rsw;
      else                              m_rsw = 0;
      al = bad | m_fail | (app == 3);
      ar = al | (app == 2 && !a_ctrl[3]);
      fu = a_ctrl[4] | pin;
      m_ml = al & !fu; m_mr = ar & !fu;
      m_src = (m_rsw != 0) ? 2'd3 : app;
   endtask

   task automatic strobe(input bit lost, input bit ber, input logic [1:0] app, input bit pin);
      @(negedge clk);
      frm_stb = 1; frm_lost = lost; ber_high = ber; app_type = app; unmute_pin = pin;
      @(negedge clk);
      frm_stb = 0; frm_lost = 0; ber_high = 0; unmute_pin = 0;
      model(lost, ber, app, pin);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rsw_sel == 1, "R1 reset source", rsw_sel, 1);
      chk(dac_mute_l && dac_mute_r && aux_mute, "R1 reset mutes",
          {dac_mute_l, dac_mute_r, aux_mute}, 7);
      chk(!mtx_sel_l && !mtx_sel_r && !gain6_en, "R1 reset routing",
          {mtx_sel_l, mtx_sel_r, gain6_en}, 0);
      chk(status[1:0] == 3, "R1 reset status", status[1:0], 3);
      rst_n = 1;
      @(negedge clk);

      // R2: write routing, no change until a strobe
      wr(1, 8'h06);
      @(negedge clk);
      chk(gain6_en == 0 && mtx_sel_r == 0 && aux_mute == 1, "R2 write deferred",
          {aux_mute, gain6_en, mtx_sel_r}, 4);

      // R4: 7 good strobes keep failure, 8th clears
      for (int i = 0; i < 7; i++) strobe(0, 0, 0, 0);
      chk(rsw_sel == 1 && dac_mute_l, "R4 still failed after 7 good", {rsw_sel, dac_mute_l}, 3);
      chk(gain6_en == 1 && mtx_sel_r == 1, "R12 routing applied at strobe", {gain6_en, mtx_sel_r}, 3);
      strobe(0, 0, 0, 0);
      chk(rsw_sel == 0 && !dac_mute_l && !dac_mute_r, "R4 recovered on 8th good",
          {rsw_sel, dac_mute_l, dac_mute_r}, 0);
      chk(status == 4'b0000, "R13 stereo status", status, 0);

      // R3 / R9: three bad frames mute but keep source
      for (int i = 0; i < 3; i++) strobe(i[0], !i[0], 0, 0);
      chk(rsw_sel == 0 && dac_mute_l && dac_mute_r, "R9 bad frame mutes, R3 not yet failed",
          {rsw_sel, dac_mute_l, dac_mute_r}, 3);
      strobe(0, 0, 0, 0);
      chk(!dac_mute_l, "R3 good strobe restarts count", dac_mute_l, 0);
      for (int i = 0; i < 4; i++) strobe(1, 0, 1, 0);
      // R6: failed, reserve disabled: hold DAC source, muted
      strobe(0, 0, 1, 0);
      chk(rsw_sel == 0 && dac_mute_l && dac_mute_r, "R6 hold source and mute",
          {rsw_sel, dac_mute_l, dac_mute_r}, 3);
      // R5: enable reserve
      wr(0, 8'h01);
      strobe(0, 0, 1, 0);
      chk(rsw_sel == 1 && status[1:0] == 3, "R5 fallback to mono", {rsw_sel, status[1:0]}, 7);
      // R11: pin unmute overrides failure
      strobe(1, 1, 0, 1);
      chk(!dac_mute_l && !dac_mute_r, "R11 pin unmute", {dac_mute_l, dac_mute_r}, 0);
      for (int i = 0; i < 8; i++) strobe(0, 0, 2, 0);
      // R10: single mono programme mutes right only
      chk(rsw_sel == 0 && !dac_mute_l && dac_mute_r && status[1:0] == 2, "R10 M1 right muted",
          {rsw_sel, dac_mute_l, dac_mute_r, status[1:0]}, 6);
      wr(0, 8'h09);
      strobe(0, 0, 2, 0);
      chk(!dac_mute_r, "R10 M1 on both DACs", dac_mute_r, 0);
      // R7: data only
      strobe(0, 0, 3, 0);
      chk(rsw_sel == 1 && dac_mute_l && dac_mute_r, "R7 data-only", {rsw_sel, dac_mute_l, dac_mute_r}, 7);
      // R8: forced stereo input, then forced mono, then both bits set = automatic
      wr(0, 8'h04);
      strobe(0, 0, 0, 0);
      chk(rsw_sel == 2, "R8 forced stereo input", rsw_sel, 2);
      wr(0, 8'h02);
      strobe(0, 0, 0, 0);
      chk(rsw_sel == 1, "R8 forced mono", rsw_sel, 1);
      wr(0, 8'h06);
      strobe(0, 0, 1, 0);
      chk(rsw_sel == 0 && status[1:0] == 1, "R8 automatic with both bits", {rsw_sel, status[1:0]}, 1);
      // R11: register unmute bit
      wr(0, 8'h10);
      strobe(1, 0, 3, 0);
      chk(!dac_mute_l && !dac_mute_r, "R11 register unmute", {dac_mute_l, dac_mute_r}, 0);
      chk_all();

      // sweep: pseudo-random frames and register contents against the model
      for (int i = 0; i < 1500; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 0) wr(lfsr[4], {3'b0, lfsr[9:5]});
         strobe(lfsr[11] & lfsr[10], lfsr[12] & lfsr[13] & lfsr[14], lfsr[15:14],
                (lfsr[7:5] == 0));
         chk_all();
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule